// File: doc/BRIEF.md
# Internal Data-Space Access Unit

This block serves every access a small accumulator-style processor core makes to its internal register space. It owns a 256-byte scratchpad RAM and steers each request either into that RAM or out onto a plain special-function-register port, whose registers live outside the block. The core issues one request per cycle. Each request carries an access mode, an 8-bit address, bit number or register number, write data and a write strobe. Read results come back one cycle later with a valid flag.

Four access modes share one 8-bit address. The mode decides what the address means. Direct byte accesses split the range: the lower half reaches RAM and the upper half reaches the register port. Indirect accesses reach all 256 RAM bytes, so upper RAM can only be reached this way. Working-register accesses select one of eight registers in the bank chosen by the status word. Single-bit accesses turn a bit number into a byte and a bit position. Single-bit writes are done as a read in one cycle and a write-back in the next.

Top module: `idata_access_unit`

## Requirements
- R1: A direct access (mode_i = 0) to an address in 00h..7Fh reads or writes scratchpad RAM at that address.
- R2: A direct access to an address in 80h..FFh goes to the register port at the same address: sfr_re_o for a read, sfr_we_o for a write. RAM at that address is left unchanged.
- R3: An indirect access (mode_i = 1) to any address 00h..FFh reads or writes RAM at that address and raises no register-port strobe.
- R4: A working-register access (mode_i = 2) to register n = addr_i[2:0] reaches RAM address bank*8 + n, where bank = psw_bank_i (bits 4:3 of the status word).
- R5: A bit access (mode_i = 3) with bit number b in 00h..7Fh targets RAM byte 20h + b[6:3], bit b[2:0].
- R6: A bit access with bit number b in 80h..FFh targets register-port byte b AND F8h, bit b[2:0], so only addresses ending in 0h or 8h are ever used for bit access.
- R7: A bit write takes its new value from wdata_i[0]. It reads the target byte in the request cycle and writes it back in the next cycle with only the selected bit changed.
- R8: busy_o is high in exactly the cycle after a bit write is accepted, and any request presented while busy_o is high is ignored.
- R9: A bit read returns the selected bit in rdata_o[0], with rdata_o[7:1] zero.
- R10: An accepted read gives rvalid_o high and its data on rdata_o in the next cycle only. A write never raises rvalid_o.
- R11: While reset is asserted and just after it, busy_o, rvalid_o, sfr_re_o and sfr_we_o are low. RAM contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | 0 direct, 1 indirect, 2 working register, 3 bit |
| addr_i | input | 8 | Address, register number or bit number |
| wdata_i | input | 8 | Write data; bit 0 is the value for bit writes |
| psw_bank_i | input | 2 | Register bank select from the status word |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Bit write-back in progress |
| sfr_addr_o | output | 8 | Register-port address |
| sfr_re_o | output | 1 | Register-port read strobe |
| sfr_we_o | output | 1 | Register-port write strobe |
| sfr_wdata_o | output | 8 | Register-port write data |
| sfr_rdata_i | input | 8 | Register-port read data, same cycle as address |

## Verification
A wrong address translation shows up on the first read of a byte that a differently-decoded access has touched. The value comes back on rdata_o one cycle after the request. A direct write wrongly sent to RAM would only show at a later indirect read of upper RAM. A bad bit merge corrupts a neighbouring bit of the target byte, which the next byte read of that address exposes. A wrong write-back phase shows on busy_o in the cycle after the bit write, or as an intruding request that changes memory.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned POS_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20;

  typedef enum logic [1:0] {
    ACC_DIRECT   = 2'd0,
    ACC_INDIRECT = 2'd1,
    ACC_WREG     = 2'd2,
    ACC_BIT      = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic              is_sfr;
    logic [ADDR_W-1:0] byte_addr;
    logic [POS_W-1:0]  bit_pos;
  } target_t;
endpackage

// File: rtl/idata_decode.sv
module idata_decode
  import idata_pkg::*;
(
  input  acc_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bank_i,
  output target_t           tgt_o
);
  localparam int unsigned REG_W = 3;
  localparam int unsigned BIDX_W = ADDR_W - 1 - POS_W;

  always_comb begin
    tgt_o = '0;
    tgt_o.bit_pos = addr_i[POS_W-1:0];
    unique case (mode_i)
      ACC_DIRECT: begin
        tgt_o.is_sfr    = addr_i[ADDR_W-1];
        tgt_o.byte_addr = addr_i;
      end
      ACC_INDIRECT: begin
        tgt_o.byte_addr = addr_i;
      end
      ACC_WREG: begin
        tgt_o.byte_addr = {{(ADDR_W-REG_W-2){1'b0}}, bank_i, addr_i[REG_W-1:0]};
      end
      ACC_BIT: begin
        if (addr_i[ADDR_W-1]) begin
          tgt_o.is_sfr    = 1'b1;
          tgt_o.byte_addr = {addr_i[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        end else begin
          tgt_o.byte_addr = BIT_RAM_BASE +
                            {{(ADDR_W-BIDX_W){1'b0}}, addr_i[ADDR_W-2:POS_W]};
        end
      end
      default: tgt_o = '0;
    endcase
  end
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/idata_bit_merge.sv
module idata_bit_merge #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              val_i,
  output logic [DATA_W-1:0] merged_o,
  output logic              bit_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign merged_o[g] = (pos_i == POS_W'(g)) ? val_i : byte_i[g];
  end
  assign bit_o = byte_i[pos_i];
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit
  import idata_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  mode_i,
  input  logic [7:0]  addr_i,
  input  logic [7:0]  wdata_i,
  input  logic [1:0]  psw_bank_i,
  output logic [7:0]  rdata_o,
  output logic        rvalid_o,
  output logic        busy_o,
  output logic [7:0]  sfr_addr_o,
  output logic        sfr_re_o,
  output logic        sfr_we_o,
  output logic [7:0]  sfr_wdata_o,
  input  logic [7:0]  sfr_rdata_i
);
  localparam int unsigned RAM_DEPTH = 1 << ADDR_W;

  acc_mode_e   mode;
  target_t     tgt;
  logic        acc, is_bit, is_rd;
  logic        wb_q, rvalid_q, rd_bit_q, sfr_sel_q, wval_q;
  target_t     tgt_q;
  logic [DATA_W-1:0] sfr_cap_q, ram_rdata, byte_q, merged;
  logic        sel_bit;
  logic        ram_re, ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  assign mode   = acc_mode_e'(mode_i);
  assign acc    = req_i && !wb_q;          // requests during write-back are dropped
  assign is_bit = (mode == ACC_BIT);
  assign is_rd  = !we_i || is_bit;         // bit write needs the old byte

  idata_decode u_decode (
    .mode_i (mode),
    .addr_i (addr_i),
    .bank_i (psw_bank_i),
    .tgt_o  (tgt)
  );

  assign ram_re    = acc && is_rd && !tgt.is_sfr;
  assign ram_we    = (acc && we_i && !is_bit && !tgt.is_sfr) || (wb_q && !sfr_sel_q);
  assign ram_waddr = wb_q ? tgt_q.byte_addr : tgt.byte_addr;
  assign ram_wdata = wb_q ? merged : wdata_i;

  idata_ram #(.DEPTH(RAM_DEPTH), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .re_i    (ram_re),
    .raddr_i (tgt.byte_addr),
    .rdata_o (ram_rdata),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata)
  );

  assign byte_q = sfr_sel_q ? sfr_cap_q : ram_rdata;

  idata_bit_merge #(.DATA_W(DATA_W)) u_merge (
    .byte_i   (byte_q),
    .pos_i    (tgt_q.bit_pos),
    .val_i    (wval_q),
    .merged_o (merged),
    .bit_o    (sel_bit)
  );

  assign sfr_addr_o  = wb_q ? tgt_q.byte_addr : tgt.byte_addr;
  assign sfr_re_o    = acc && is_rd && tgt.is_sfr;
  assign sfr_we_o    = (acc && we_i && !is_bit && tgt.is_sfr) || (wb_q && sfr_sel_q);
  assign sfr_wdata_o = wb_q ? merged : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q      <= 1'b0;
      rvalid_q  <= 1'b0;
      rd_bit_q  <= 1'b0;
      sfr_sel_q <= 1'b0;
      wval_q    <= 1'b0;
      tgt_q     <= '0;
      sfr_cap_q <= '0;
    end else begin
      wb_q     <= acc && we_i && is_bit;
      rvalid_q <= acc && !we_i;
      if (acc) begin
        rd_bit_q  <= is_bit;
        sfr_sel_q <= tgt.is_sfr;
        wval_q    <= wdata_i[0];
        tgt_q     <= tgt;
      end
      if (sfr_re_o) sfr_cap_q <= sfr_rdata_i;
    end
  end

  assign busy_o   = wb_q;
  assign rvalid_o = rvalid_q;
  always_comb begin
    rdata_o = '0;
    if (rvalid_q) rdata_o = rd_bit_q ? {{(DATA_W-1){1'b0}}, sel_bit} : byte_q;
  end
endmodule

// File: rtl/idata_access_unit_chk.sv
module idata_access_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       we_i,
  input logic [1:0] mode_i,
  input logic [7:0] addr_i,
  input logic [7:0] rdata_o,
  input logic       rvalid_o,
  input logic       busy_o,
  input logic [7:0] sfr_addr_o,
  input logic       sfr_re_o,
  input logic       sfr_we_o,
  input logic [7:0] sfr_wdata_o,
  input logic [7:0] sfr_rdata_i
);
  AST_DIRECT_HIGH_TO_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i == 2'd0 && addr_i[7]) |-> (sfr_re_o || sfr_we_o)); // R2
  AST_INDIRECT_NO_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && mode_i == 2'd1) |-> (!sfr_re_o && !sfr_we_o)); // R3
  AST_PORT_BIT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sfr_we_o) |-> (sfr_addr_o[2:0] == 3'd0)); // R6
  AST_WB_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && sfr_we_o) |-> ($countones(sfr_wdata_o ^ $past(sfr_rdata_i)) <= 1)); // R7
  AST_BIT_WRITE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && we_i && mode_i == 2'd3) |=> busy_o); // R8
  AST_BUSY_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R8
  AST_BIT_READ_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !we_i && mode_i == 2'd3) |=> (rdata_o[7:1] == 7'd0)); // R9
  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !we_i) |=> rvalid_o); // R10
  AST_WRITE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !busy_o && !we_i) |=> !rvalid_o); // R10
endmodule

bind idata_access_unit idata_access_unit_chk chk_i (.*);

// File: tb/idata_access_unit_tb_top.sv
module idata_access_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       req = 1'b0, we = 1'b0;
  logic [1:0] mode = '0, bank = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, sfr_addr, sfr_wdata, sfr_rdata;
  logic       rvalid, busy, sfr_re, sfr_we;

  idata_access_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
    .addr_i(addr), .wdata_i(wdata), .psw_bank_i(bank), .rdata_o(rdata),
    .rvalid_o(rvalid), .busy_o(busy), .sfr_addr_o(sfr_addr), .sfr_re_o(sfr_re),
    .sfr_we_o(sfr_we), .sfr_wdata_o(sfr_wdata), .sfr_rdata_i(sfr_rdata)
  );

  // register file behind the port
  logic [7:0] sfr_mem [256];
  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr] <= sfr_wdata;

  logic [7:0] ref_ram [256];
  logic [7:0] ref_sfr [256];
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       done = 1'b0;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk("R10 unexpected rvalid", 8'd1, 8'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  logic intrude = 1'b0;

  task automatic acc(input string r, input logic [1:0] m, input logic w,
                     input logic [7:0] a, input logic [7:0] d);
    logic is_sfr;
    logic [7:0] b;
    logic [2:0] p;
    logic [7:0] old;
    p = a[2:0];
    case (m)
      2'd0: begin is_sfr = a[7]; b = a; end
      2'd1: begin is_sfr = 1'b0; b = a; end
      2'd2: begin is_sfr = 1'b0; b = {3'b000, bank, a[2:0]}; end
      default: begin
        is_sfr = a[7];
        b = a[7] ? (a & 8'hF8) : (8'h20 + {4'h0, a[6:3]});
      end
    endcase
    old = is_sfr ? ref_sfr[b] : ref_ram[b];
    if (!w) begin
      exp_q.push_back(m == 2'd3 ? {7'd0, old[p]} : old);
      tag_q.push_back(r);
    end else begin
      if (m == 2'd3) old[p] = d[0]; else old = d;
      if (is_sfr) ref_sfr[b] = old; else ref_ram[b] = old;
    end
    req = 1'b1; we = w; mode = m; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0;
    if (w) chk({r, " R10 no rvalid after write"}, {7'd0, rvalid}, 8'd0);
    if (w && m == 2'd3) begin
      chk({r, " R8 busy high"}, {7'd0, busy}, 8'd1);
      if (intrude) begin
        req = 1'b1; we = 1'b1; mode = 2'd1; addr = 8'h50; wdata = ~ref_ram[8'h50];
      end
      @(posedge clk); #1;
      req = 1'b0;
      chk({r, " R8 busy low"}, {7'd0, busy}, 8'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sfr_mem[i] = 8'(i * 13 + 7);
      ref_sfr[i] = 8'(i * 13 + 7);
    end
    repeat (3) @(posedge clk); #1;
    chk("R11 busy in reset", {7'd0, busy}, 8'd0);
    chk("R11 rvalid in reset", {7'd0, rvalid}, 8'd0);
    chk("R11 strobes in reset", {6'd0, sfr_re, sfr_we}, 8'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 strobes after reset", {5'd0, busy, sfr_re, sfr_we}, 8'd0);

    for (int i = 0; i < 256; i++) acc("R3 init", 2'd1, 1'b1, 8'(i), 8'(i * 37 + 5));

    acc("R1 direct read 00", 2'd0, 1'b0, 8'h00, 8'h00);
    acc("R1 direct read 7F", 2'd0, 1'b0, 8'h7F, 8'h00);
    acc("R1 direct write 10", 2'd0, 1'b1, 8'h10, 8'h5A);
    acc("R1 read back 10", 2'd1, 1'b0, 8'h10, 8'h00);

    acc("R2 direct read 85", 2'd0, 1'b0, 8'h85, 8'h00);
    acc("R2 direct write 90", 2'd0, 1'b1, 8'h90, 8'hC3);
    acc("R2 RAM 90 untouched", 2'd1, 1'b0, 8'h90, 8'h00);
    acc("R2 port 90 read", 2'd0, 1'b0, 8'h90, 8'h00);
    acc("R2 direct read 80", 2'd0, 1'b0, 8'h80, 8'h00);
    acc("R2 direct read FF", 2'd0, 1'b0, 8'hFF, 8'h00);

    acc("R3 indirect write A7", 2'd1, 1'b1, 8'hA7, 8'h11);
    acc("R3 indirect read A7", 2'd1, 1'b0, 8'hA7, 8'h00);
    acc("R3 port A7 untouched", 2'd0, 1'b0, 8'hA7, 8'h00);
    acc("R3 indirect read FF", 2'd1, 1'b0, 8'hFF, 8'h00);

    for (int k = 0; k < 4; k++) begin
      bank = 2'(k);
      acc("R4 wreg write R5", 2'd2, 1'b1, 8'h05, 8'(8'h40 + k));
      acc("R4 indirect view", 2'd1, 1'b0, 8'(k * 8 + 5), 8'h00);
    end
    bank = 2'd2;
    acc("R4 wreg read R2 bank2", 2'd2, 1'b0, 8'hFA, 8'h00);

    acc("R5 R9 bit read 3D", 2'd3, 1'b0, 8'h3D, 8'h00);
    acc("R5 R9 bit read 7F", 2'd3, 1'b0, 8'h7F, 8'h00);
    acc("R5 R9 bit read 00", 2'd3, 1'b0, 8'h00, 8'h00);
    intrude = 1'b1;
    acc("R7 bit write 3D", 2'd3, 1'b1, 8'h3D, {7'd0, ~ref_ram[8'h27][5]});
    intrude = 1'b0;
    acc("R7 byte 27 after bit write", 2'd1, 1'b0, 8'h27, 8'h00);
    acc("R8 intruder ignored 50", 2'd1, 1'b0, 8'h50, 8'h00);
    acc("R7 bit write 7F", 2'd3, 1'b1, 8'h7F, {7'd0, ~ref_ram[8'h2F][7]});
    acc("R7 byte 2F", 2'd1, 1'b0, 8'h2F, 8'h00);
    acc("R7 bit write 00", 2'd3, 1'b1, 8'h00, {7'd0, ~ref_ram[8'h20][0]});
    acc("R7 byte 20", 2'd1, 1'b0, 8'h20, 8'h00);

    acc("R6 R9 bit read 9B", 2'd3, 1'b0, 8'h9B, 8'h00);
    acc("R6 R7 bit write 9B", 2'd3, 1'b1, 8'h9B, {7'd0, ~ref_sfr[8'h98][3]});
    acc("R6 port 98 after bit write", 2'd0, 1'b0, 8'h98, 8'h00);
    acc("R6 R7 bit write F7", 2'd3, 1'b1, 8'hF7, {7'd0, ~ref_sfr[8'hF0][7]});
    acc("R6 port F0", 2'd0, 1'b0, 8'hF0, 8'h00);
    acc("R6 RAM F0 untouched", 2'd1, 1'b0, 8'hF0, 8'h00);

    repeat (3) @(posedge clk); #1;
    chk("R10 all reads answered", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule